// File: doc/BRIEF.md
# Multiprocessor Interrupt Controller Core

This block gathers a parameterised set of interrupt request lines and routes them to a small group of processors. Each line can become pending in two ways: its input pin is high, or software has set its pending bit. A line reaches a processor only if it is unmasked and that processor's bit is set in the line's routing mask. Each processor has a registered IRQ output that stays high while at least one line is eligible for it.

All access goes through one 32-bit register bus. The bus carries the index of the processor making the access. Each processor reads its own event register. The read returns the lowest-numbered eligible line as a packed word (die, type, number). The same read masks that line, so it cannot fire again until the handler has finished. The handler then clears the software-pending bit and unmasks the line, using separate write-one-to-set and write-one-to-clear banks. An identification register reports the number of lines and the die count. A who-am-I register reports the index of the processor doing the read.

Input pins are level-sensitive. A source that produces pulses should be latched into the software-pending bank, or held high until it is serviced.

Top module: `mpic_core`

## Requirements
- R1: After reset every line is masked, every software-pending bit is 0, every routing mask is 0 and every IRQ output is low. The mask banks read back all ones for the implemented lines.
- R2: A read of offset 0x0004 returns the number of implemented lines in bits 15:0 and the die count minus one (0) in bits 27:24. All other bits are 0.
- R3: A read of offset 0x2000 returns the index of the processor that carries out the read.
- R4: The software-set bank starts at 0x4000, the software-clear bank at 0x4080, the mask-set bank at 0x4100 and the mask-clear bank at 0x4180. Line n is bit n&31 of word n>>5 in each bank. A written 1 sets or clears only that bit, and a written 0 has no effect. A read of either set or clear address returns the current word.
- R5: A line is pending when its input is high or its software-pending bit is 1. IRQ output c is high, one cycle after the state changes, exactly when some pending, unmasked line has bit c set in its routing mask.
- R6: A read of offset 0x2004 returns {8'd0 die, 8'd1 type, 16-bit line number} for the lowest-numbered line eligible for the reading processor.
- R7: An event read that returns a line sets that line's mask bit. The line is then not delivered again until it is unmasked.
- R8: An event read with no eligible line returns 0 and changes no state.
- R9: The routing mask of line n is at 0x3000 + 4*n, in bits NUM_CPUS-1:0. Bits above these read back as 0. A routing write to a line at or above the implemented count is ignored, and reading that address returns 0.
- R10: Bank bits for line numbers at or above the implemented count read 0 and are never reported.
- R11: Read data and its valid flag appear exactly one cycle after the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | NUM_LINES | Level interrupt inputs |
| bus_rd | input | 1 | Read request |
| bus_wr | input | 1 | Write request |
| bus_cpu | input | $clog2(NUM_CPUS) | Index of the requesting processor |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid |
| irq_out | output | NUM_CPUS | Per-processor interrupt request |

## Verification
An event read and a rising interrupt input can fall in the same cycle. Because selection is made from the live pending state, a line that rises during the read cycle competes in that read. The bench first makes line 30 eligible for processor 0. It then raises line 20 in exactly the cycle of the event read, and expects the read to report 20, not 30. A second read must then report 30, which shows that only line 20 was masked by the first read.

// File: rtl/mpic_pkg.sv
package mpic_pkg;
  // fixed register offsets
  localparam logic [15:0] OFF_INFO = 16'h0004;
  localparam logic [15:0] OFF_WHO  = 16'h2000;
  localparam logic [15:0] OFF_EVT  = 16'h2004;
  // 128-byte pages holding the set/clear banks (addr[15:7])
  localparam logic [8:0]  PG_SWSET = 9'h080;
  localparam logic [8:0]  PG_SWCLR = 9'h081;
  localparam logic [8:0]  PG_MSET  = 9'h082;
  localparam logic [8:0]  PG_MCLR  = 9'h083;
  // 4 KiB region of routing words (addr[15:12])
  localparam logic [3:0]  PG_ROUTE = 4'h3;

  typedef enum logic [7:0] {
    EV_NONE  = 8'd0,
    EV_HWIRQ = 8'd1,
    EV_IPI   = 8'd4
  } ev_type_e;
endpackage

// File: rtl/mpic_bank.sv
module mpic_bank #(
  parameter int NUM_LINES = 40,
  parameter int WORDS     = 2,
  parameter int WIDX      = 1,
  parameter bit RST_ONE   = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 set_we,
  input  logic                 clr_we,
  input  logic [WIDX-1:0]      word,
  input  logic [31:0]          wdata,
  input  logic [NUM_LINES-1:0] hw_set,
  output logic [NUM_LINES-1:0] q,
  output logic [31:0]          rd_word
);
  logic [NUM_LINES-1:0] sel;
  logic [WORDS*32-1:0]  padded;

  // expand one written word to a per-line select
  always_comb begin
    for (int i = 0; i < NUM_LINES; i++)
      sel[i] = (word == WIDX'(i / 32)) && wdata[i % 32];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= {NUM_LINES{RST_ONE}};
    end else begin
      for (int i = 0; i < NUM_LINES; i++) begin
        if (set_we && sel[i])      q[i] <= 1'b1;
        else if (clr_we && sel[i]) q[i] <= 1'b0;
        if (hw_set[i])             q[i] <= 1'b1;
      end
    end
  end

  always_comb begin
    padded = '0;
    padded[NUM_LINES-1:0] = q;
    rd_word = padded[32*word +: 32];
  end

  // R4
  clr_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_we && !set_we && hw_set == '0) |=> ((q & $past(sel)) == '0));
endmodule

// File: rtl/mpic_route.sv
module mpic_route #(
  parameter int NUM_LINES = 40,
  parameter int NUM_CPUS  = 4,
  parameter int LW        = 6
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                we,
  input  logic [LW-1:0]                       line,
  input  logic [NUM_CPUS-1:0]                 wdata,
  output logic [NUM_CPUS-1:0][NUM_LINES-1:0]  tgt,
  output logic [NUM_CPUS-1:0]                 rd_tgt
);
  logic [NUM_CPUS-1:0] rt [NUM_LINES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_LINES; i++) rt[i] <= '0;
    end else if (we) begin
      rt[line] <= wdata;
    end
  end

  always_comb begin
    for (int c = 0; c < NUM_CPUS; c++)
      for (int i = 0; i < NUM_LINES; i++)
        tgt[c][i] = rt[i][c];
  end

  assign rd_tgt = rt[line];
endmodule

// File: rtl/mpic_pick.sv
module mpic_pick #(
  parameter int NUM_LINES = 40,
  parameter int NUM_CPUS  = 4,
  parameter int LW        = 6
) (
  input  logic [NUM_CPUS-1:0][NUM_LINES-1:0] elig,
  output logic [NUM_CPUS-1:0]                any_o,
  output logic [NUM_CPUS-1:0][LW-1:0]        num_o
);
  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    logic          any_l;
    logic [LW-1:0] num_l;
    always_comb begin
      any_l = |elig[c];
      num_l = '0;
      for (int i = NUM_LINES - 1; i >= 0; i--)
        if (elig[c][i]) num_l = LW'(i);
    end
    assign any_o[c] = any_l;
    assign num_o[c] = num_l;
  end
endmodule

// File: rtl/mpic_core.sv
module mpic_core
  import mpic_pkg::*;
#(
  parameter int NUM_LINES = 40,
  parameter int NUM_CPUS  = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_LINES-1:0]        irq_lines,
  input  logic                        bus_rd,
  input  logic                        bus_wr,
  input  logic [$clog2(NUM_CPUS)-1:0] bus_cpu,
  input  logic [15:0]                 bus_addr,
  input  logic [31:0]                 bus_wdata,
  output logic [31:0]                 bus_rdata,
  output logic                        bus_rvalid,
  output logic [NUM_CPUS-1:0]         irq_out
);
  localparam int WORDS = (NUM_LINES + 31) / 32;
  localparam int WIDX  = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int LW    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
  localparam logic [3:0] DIE_M1 = 4'd0;

  logic [NUM_LINES-1:0] swpend, mask, pend, avail, ack_set;
  logic [NUM_CPUS-1:0][NUM_LINES-1:0] tgt, elig;
  logic [NUM_CPUS-1:0]          any;
  logic [NUM_CPUS-1:0][LW-1:0]  num;
  logic [NUM_CPUS-1:0]          rd_tgt;
  logic [31:0] sw_word, mask_word, rd_mux;

  // address decode
  logic [8:0]      page;
  logic [4:0]      wsel;
  logic            word_ok, route_ok, ack, is_evt;
  logic [WIDX-1:0] widx;
  logic [9:0]      rline;

  assign page     = bus_addr[15:7];
  assign wsel     = bus_addr[6:2];
  assign word_ok  = (wsel < 5'(WORDS));
  assign widx     = WIDX'(wsel);
  assign rline    = bus_addr[11:2];
  assign route_ok = (bus_addr[15:12] == PG_ROUTE) && (rline < 10'(NUM_LINES));
  assign is_evt   = bus_rd && (bus_addr == OFF_EVT);
  assign ack      = is_evt && any[bus_cpu];

  always_comb begin
    ack_set = '0;
    if (ack) ack_set[num[bus_cpu]] = 1'b1;
  end

  mpic_bank #(.NUM_LINES(NUM_LINES), .WORDS(WORDS), .WIDX(WIDX), .RST_ONE(1'b0)) u_swpend (
    .clk(clk), .rst(rst),
    .set_we(bus_wr && page == PG_SWSET && word_ok),
    .clr_we(bus_wr && page == PG_SWCLR && word_ok),
    .word(widx), .wdata(bus_wdata), .hw_set('0),
    .q(swpend), .rd_word(sw_word));

  mpic_bank #(.NUM_LINES(NUM_LINES), .WORDS(WORDS), .WIDX(WIDX), .RST_ONE(1'b1)) u_mask (
    .clk(clk), .rst(rst),
    .set_we(bus_wr && page == PG_MSET && word_ok),
    .clr_we(bus_wr && page == PG_MCLR && word_ok),
    .word(widx), .wdata(bus_wdata), .hw_set(ack_set),
    .q(mask), .rd_word(mask_word));

  mpic_route #(.NUM_LINES(NUM_LINES), .NUM_CPUS(NUM_CPUS), .LW(LW)) u_route (
    .clk(clk), .rst(rst), .we(bus_wr && route_ok), .line(LW'(rline)),
    .wdata(bus_wdata[NUM_CPUS-1:0]), .tgt(tgt), .rd_tgt(rd_tgt));

  assign pend  = irq_lines | swpend;
  assign avail = pend & ~mask;
  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_elig
    assign elig[c] = avail & tgt[c];
  end

  mpic_pick #(.NUM_LINES(NUM_LINES), .NUM_CPUS(NUM_CPUS), .LW(LW)) u_pick (
    .elig(elig), .any_o(any), .num_o(num));

  always_comb begin
    rd_mux = '0;
    if (bus_addr == OFF_INFO)
      rd_mux = {4'd0, DIE_M1, 8'd0, 16'(NUM_LINES)};
    else if (bus_addr == OFF_WHO)
      rd_mux = 32'(bus_cpu);
    else if (is_evt && any[bus_cpu])
      rd_mux = {8'd0, EV_HWIRQ, 16'(num[bus_cpu])};
    else if ((page == PG_SWSET || page == PG_SWCLR) && word_ok)
      rd_mux = sw_word;
    else if ((page == PG_MSET || page == PG_MCLR) && word_ok)
      rd_mux = mask_word;
    else if (route_ok)
      rd_mux = 32'(rd_tgt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
      irq_out    <= '0;
    end else begin
      bus_rvalid <= bus_rd;
      irq_out    <= any;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> ((&mask) && swpend == '0 && irq_out == '0));
  // R7
  ack_mask_chk: assert property (@(posedge clk) disable iff (rst)
    ack |=> mask[$past(num[bus_cpu])]);
  // R11
  rvalid_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rvalid |-> $past(bus_rd));
  // R6
  event_fields_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rvalid && $past(bus_addr) == OFF_EVT && bus_rdata != '0)
      |-> (bus_rdata[31:16] == 16'h0001 && bus_rdata[15:0] < 16'(NUM_LINES)));
endmodule

// File: tb/mpic_core_test.sv
`timescale 1ns/1ps
module mpic_core_test;
  localparam int NL = 40;
  localparam int NC = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NL-1:0] irq_lines = '0;
  logic bus_rd = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_cpu = '0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic bus_rvalid;
  logic [NC-1:0] irq_out;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  mpic_core #(.NUM_LINES(NL), .NUM_CPUS(NC)) uut (
    .clk(clk), .rst(rst), .irq_lines(irq_lines), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_cpu(bus_cpu), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .irq_out(irq_out));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] cpu, input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_cpu = cpu; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    chk("R11 rvalid", 32'(bus_rvalid), 32'd1);
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic clean();
    irq_lines = '0;
    wr(16'h4080, 32'hFFFF_FFFF); wr(16'h4084, 32'hFFFF_FFFF);
    wr(16'h4100, 32'hFFFF_FFFF); wr(16'h4104, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq_out", 32'(irq_out), 32'd0);
    rd(2'd0, 16'h4100, d); chk("R1 mask w0", d, 32'hFFFF_FFFF);
    rd(2'd0, 16'h4104, d); chk("R10 mask w1", d, 32'h0000_00FF);
    rd(2'd0, 16'h4000, d); chk("R1 swpend w0", d, 32'd0);
    rd(2'd0, 16'h3000, d); chk("R1 route0", d, 32'd0);
    rd(2'd0, 16'h2004, d); chk("R1 event", d, 32'd0);
  endtask

  task automatic t_info();
    logic [31:0] d;
    rd(2'd1, 16'h0004, d); chk("R2 info", d, 32'h0000_0028);
    rd(2'd2, 16'h2000, d); chk("R3 whoami2", d, 32'd2);
    rd(2'd3, 16'h2000, d); chk("R3 whoami3", d, 32'd3);
  endtask

  task automatic t_banks();
    logic [31:0] d;
    wr(16'h4000, 32'h0000_00F0);
    wr(16'h4000, 32'h0000_0003);
    rd(2'd0, 16'h4000, d); chk("R4 set or", d, 32'h0000_00F3);
    wr(16'h4080, 32'h0000_0021);
    rd(2'd0, 16'h4080, d); chk("R4 clr", d, 32'h0000_00D2);
    wr(16'h4004, 32'hFFFF_FFFF);
    rd(2'd0, 16'h4004, d); chk("R10 swpend w1", d, 32'h0000_00FF);
    wr(16'h4180, 32'h0000_0100);
    rd(2'd0, 16'h4100, d); chk("R4 mask clr", d, 32'hFFFF_FEFF);
    clean();
  endtask

  task automatic t_route();
    logic [31:0] d;
    wr(16'h3014, 32'h6);
    rd(2'd0, 16'h3014, d); chk("R9 route5", d, 32'h6);
    wr(16'h3018, 32'hFF);
    rd(2'd0, 16'h3018, d); chk("R9 route6 width", d, 32'hF);
    wr(16'h30B4, 32'hF);
    rd(2'd0, 16'h30B4, d); chk("R9 route45 ignored", d, 32'd0);
    wr(16'h3014, 32'h0); wr(16'h3018, 32'h0);
  endtask

  task automatic t_deliver();
    logic [31:0] d;
    wr(16'h301C, 32'h2);
    wr(16'h4180, 32'h0000_0080);
    irq_lines[7] = 1'b1;
    settle();
    chk("R5 irq cpu1", 32'(irq_out), 32'h2);
    rd(2'd0, 16'h2004, d); chk("R8 cpu0 none", d, 32'd0);
    rd(2'd1, 16'h2004, d); chk("R6 event line7", d, 32'h0001_0007);
    settle();
    chk("R7 irq dropped", 32'(irq_out), 32'h0);
    rd(2'd0, 16'h4100, d); chk("R7 mask bit7", d & 32'h80, 32'h80);
    rd(2'd1, 16'h2004, d); chk("R8 second read", d, 32'd0);
    wr(16'h4180, 32'h0000_0080);
    settle();
    chk("R7 unmask refires", 32'(irq_out), 32'h2);
    clean(); wr(16'h301C, 32'h0);
  endtask

  task automatic t_priority();
    logic [31:0] d;
    wr(16'h300C, 32'h4); wr(16'h308C, 32'h4);
    wr(16'h4004, 32'h8); wr(16'h4000, 32'h8);
    wr(16'h4184, 32'h8); wr(16'h4180, 32'h8);
    rd(2'd2, 16'h2004, d); chk("R6 lowest 3", d, 32'h0001_0003);
    rd(2'd2, 16'h2004, d); chk("R6 next 35", d, 32'h0001_0023);
    rd(2'd2, 16'h2004, d); chk("R8 empty", d, 32'd0);
    wr(16'h4180, 32'h0000_0400);
    wr(16'h4000, 32'h0000_0400);
    settle();
    chk("R5 unrouted line", 32'(irq_out), 32'h0);
    clean(); wr(16'h300C, 32'h0); wr(16'h308C, 32'h0);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    wr(16'h3050, 32'h1); wr(16'h3078, 32'h1);
    wr(16'h4000, 32'h4000_0000);
    wr(16'h4180, 32'h4010_0000);
    @(negedge clk);
    irq_lines[20] = 1'b1;
    bus_rd = 1'b1; bus_cpu = 2'd0; bus_addr = 16'h2004;
    @(negedge clk);
    bus_rd = 1'b0;
    chk("R6 same-cycle rise wins", bus_rdata, 32'h0001_0014);
    rd(2'd0, 16'h2004, d); chk("R7 then 30", d, 32'h0001_001E);
    clean(); wr(16'h3050, 32'h0); wr(16'h3078, 32'h0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_info();
    t_banks();
    t_route();
    t_deliver();
    t_priority();
    t_collide();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule